// File: doc/BRIEF.md
# Outbound MMIO Window Partition Decoder

This block sits on the outbound path of a host bridge. Each CPU load or store address is compared against one 32-bit translating window and sixteen 64-bit pass-through windows. The decoder returns the address to place on the bus and the isolation group (partition number) that owns the access. If no enabled window claims the address, it raises a miss flag.

The 32-bit window keeps the address bits below its size and takes the bits above from a programmed substitute value. It is cut into 256 equal segments, and a 256-entry table gives the group of each segment. A 64-bit window never alters the address. In single-group mode it returns one programmed group for its whole range. In segmented mode it is cut into 256 segments and the segment index is the group. Windows may overlap, and a fixed priority picks one winner.

A small state machine sequences each lookup through four states: `S_IDLE`, `S_MATCH`, `S_LOOKUP` and `S_RESP`. The transitions are:
- ACCEPT: `S_IDLE` to `S_MATCH` when a request is taken.
- COMPARE_DONE: `S_MATCH` to `S_LOOKUP`.
- TABLE_DONE: `S_LOOKUP` to `S_RESP`.
- RESP_DONE: `S_RESP` to `S_IDLE`.

`S_MATCH` compares the address against all windows and starts the table read. `S_LOOKUP` merges the table data. `S_RESP` presents the result. Software programs the windows and the table through a write-only register port.

Top module: `mmio_win_decoder`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0. All windows start disabled and the table starts zeroed, so any request misses.
- R2: The decoder takes a request on a rising edge where req_valid and req_ready are both 1. rsp_valid is then 1 for exactly one cycle, starting after the third rising edge counted from acceptance. req_ready is 0 from acceptance until rsp_valid falls.
- R3: On a 32-bit window hit, the bus address keeps the request bits below the window size. The bits above the size come from the substitute value. The size field (log2 bytes) is clamped to the range 8 to 32.
- R4: On a 32-bit window hit, the group is the table entry indexed by the 8 request bits just below the window size. A register write at offset 0x000+i (i = 0..255) loads table entry i from wdata[7:0].
- R5: On a 64-bit window hit, the bus address equals the request address.
- R6: In segmented mode, a 64-bit window returns as group the 8 request bits just below its size. Its size field is clamped to the range 28 to 48.
- R7: In single-group mode, a 64-bit window returns its programmed group for every address in its range.
- R8: The 32-bit window beats every 64-bit window. Among 64-bit windows, the lowest-numbered hit wins. rsp_win reports the winner: 0..15 for a 64-bit window and 16 for the 32-bit window.
- R9: An address that hits no enabled window gives rsp_miss = 1 with rsp_win, rsp_group and rsp_bus_addr all 0.
- R10: Each window is naturally aligned. Base bits below the window size are ignored when matching.
- R11: A window whose enable bit is 0 never matches.
- R12: The register map is as follows.
  - 32-bit window: base at 0x100, control at 0x101 (size in [5:0], enable in [8]), substitute value at 0x102.
  - 64-bit window w: base at 0x200+2w, control at 0x201+2w (size in [5:0], enable in [8], segmented in [9], group in [23:16]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register offset |
| cfg_wdata | input | 48 | Register write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Decoder idle, request can be taken |
| req_addr | input | 48 | CPU address to decode |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_miss | output | 1 | No enabled window claimed the address |
| rsp_win | output | 5 | Winning window, 16 for the 32-bit window |
| rsp_group | output | 8 | Partition group number |
| rsp_bus_addr | output | 48 | Address presented on the bus |

## Verification
Each request is checked cycle by cycle against the handshake timing. A state register that skips or stalls a state shows at once as rsp_valid appearing in the wrong cycle or req_ready staying low. A wrong hit vector, priority pick or latched segment index shows in the single response cycle as a wrong winner, group or bus address. Overlapping windows, segment 0 and segment 255, one address past a window's top, clamped sizes, unaligned bases and disabled windows are all exercised, so a fault in the compare, clamp or table-read path reaches the response fields within three cycles of acceptance.

// File: rtl/mwd_pkg.sv
`timescale 1ns/1ps
package mwd_pkg;
    localparam int ADDR_W      = 48;
    localparam int N64         = 16;
    localparam int SEG_W       = 8;
    localparam int GRP_W       = 8;
    localparam int LOG_W       = 6;
    localparam int CFG_AW      = 10;
    localparam int M32_MAX_LOG = 32;
    localparam int M64_MIN_LOG = 28;

    // register pages (cfg_addr above the segment bits)
    localparam int PG_TBL = 0;
    localparam int PG_M32 = 1;
    localparam int PG_M64 = 2;

    // control word field positions
    localparam int CTL_EN_BIT  = 8;
    localparam int CTL_SEG_BIT = 9;
    localparam int CTL_GRP_LSB = 16;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MATCH,
        S_LOOKUP,
        S_RESP
    } dec_state_t;
endpackage

// File: rtl/mwd_win_match.sv
`timescale 1ns/1ps
module mwd_win_match #(
    parameter int ADDR_W  = 48,
    parameter int LOG_W   = 6,
    parameter int SEG_W   = 8,
    parameter int MIN_LOG = 8,
    parameter int MAX_LOG = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] subst,
    input  logic [LOG_W-1:0]  size_log,
    input  logic              en,
    output logic              hit,
    output logic [SEG_W-1:0]  seg,
    output logic [ADDR_W-1:0] xlat
);
    logic [LOG_W-1:0]  eff;
    logic [ADDR_W-1:0] mask;

    always_comb begin
        if (size_log < LOG_W'(MIN_LOG)) begin
            eff = LOG_W'(MIN_LOG);
        end else if (size_log > LOG_W'(MAX_LOG)) begin
            eff = LOG_W'(MAX_LOG);
        end else begin
            eff = size_log;
        end
        mask = {ADDR_W{1'b1}} >> (ADDR_W - int'(eff));
        hit  = en && ((addr & ~mask) == (base & ~mask));
        seg  = SEG_W'(addr >> (int'(eff) - SEG_W));
        xlat = (subst & ~mask) | (addr & mask);
    end
endmodule

// File: rtl/mwd_seg_table.sv
`timescale 1ns/1ps
module mwd_seg_table #(
    parameter int IDX_W = 8,
    parameter int GRP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [GRP_W-1:0] wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output logic [GRP_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [GRP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/mwd_cfg_regs.sv
`timescale 1ns/1ps
module mwd_cfg_regs
    import mwd_pkg::*;
#(
    parameter int ADDR_W = mwd_pkg::ADDR_W,
    parameter int N64    = mwd_pkg::N64,
    parameter int LOG_W  = mwd_pkg::LOG_W,
    parameter int GRP_W  = mwd_pkg::GRP_W,
    parameter int SEG_W  = mwd_pkg::SEG_W,
    parameter int CFG_AW = mwd_pkg::CFG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              tbl_we,
    output logic [SEG_W-1:0]  tbl_waddr,
    output logic [GRP_W-1:0]  tbl_wdata,
    output logic [ADDR_W-1:0] m32_base,
    output logic [ADDR_W-1:0] m32_upper,
    output logic [LOG_W-1:0]  m32_log,
    output logic              m32_en,
    output logic [ADDR_W-1:0] m64_base [N64],
    output logic [LOG_W-1:0]  m64_log  [N64],
    output logic [N64-1:0]    m64_en,
    output logic [N64-1:0]    m64_seg,
    output logic [GRP_W-1:0]  m64_grp  [N64]
);
    localparam int PG_W = CFG_AW - SEG_W;

    logic [PG_W-1:0]  page;
    logic [SEG_W-1:0] off;
    logic             wr_m32;
    logic             wr_m64;

    assign page      = cfg_addr[CFG_AW-1:SEG_W];
    assign off       = cfg_addr[SEG_W-1:0];
    assign tbl_we    = cfg_we && (page == PG_W'(PG_TBL));
    assign tbl_waddr = off;
    assign tbl_wdata = cfg_wdata[GRP_W-1:0];
    assign wr_m32    = cfg_we && (page == PG_W'(PG_M32));
    assign wr_m64    = cfg_we && (page == PG_W'(PG_M64));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m32_base  <= '0;
            m32_upper <= '0;
            m32_log   <= '0;
            m32_en    <= 1'b0;
        end else if (wr_m32) begin
            if (off == SEG_W'(0)) begin
                m32_base <= cfg_wdata;
            end
            if (off == SEG_W'(1)) begin
                m32_log <= cfg_wdata[LOG_W-1:0];
                m32_en  <= cfg_wdata[CTL_EN_BIT];
            end
            if (off == SEG_W'(2)) begin
                m32_upper <= cfg_wdata;
            end
        end
    end

    for (genvar w = 0; w < N64; w++) begin : g_m64
        logic hit_w;
        assign hit_w = wr_m64 && (off[SEG_W-1:1] == (SEG_W-1)'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m64_base[w] <= '0;
                m64_log[w]  <= '0;
                m64_en[w]   <= 1'b0;
                m64_seg[w]  <= 1'b0;
                m64_grp[w]  <= '0;
            end else if (hit_w) begin
                if (!off[0]) begin
                    m64_base[w] <= cfg_wdata;
                end else begin
                    m64_log[w] <= cfg_wdata[LOG_W-1:0];
                    m64_en[w]  <= cfg_wdata[CTL_EN_BIT];
                    m64_seg[w] <= cfg_wdata[CTL_SEG_BIT];
                    m64_grp[w] <= cfg_wdata[CTL_GRP_LSB +: GRP_W];
                end
            end
        end
    end
endmodule

// File: rtl/mmio_win_decoder.sv
`timescale 1ns/1ps
module mmio_win_decoder
    import mwd_pkg::*;
#(
    parameter int ADDR_W      = mwd_pkg::ADDR_W,
    parameter int N64         = mwd_pkg::N64,
    parameter int SEG_W       = mwd_pkg::SEG_W,
    parameter int GRP_W       = mwd_pkg::GRP_W,
    parameter int LOG_W       = mwd_pkg::LOG_W,
    parameter int CFG_AW      = mwd_pkg::CFG_AW,
    parameter int M32_MAX_LOG = mwd_pkg::M32_MAX_LOG,
    parameter int M64_MIN_LOG = mwd_pkg::M64_MIN_LOG,
    localparam int WIN_W      = $clog2(N64 + 1),
    localparam int IDX_W      = $clog2(N64)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic [WIN_W-1:0]  rsp_win,
    output logic [GRP_W-1:0]  rsp_group,
    output logic [ADDR_W-1:0] rsp_bus_addr
);
    localparam logic [WIN_W-1:0] M32_ID = WIN_W'(N64);

    // configuration
    logic              tbl_we;
    logic [SEG_W-1:0]  tbl_waddr;
    logic [GRP_W-1:0]  tbl_wdata;
    logic [GRP_W-1:0]  tbl_rdata;
    logic [ADDR_W-1:0] m32_base;
    logic [ADDR_W-1:0] m32_upper;
    logic [LOG_W-1:0]  m32_log;
    logic              m32_en;
    logic [ADDR_W-1:0] m64_base [N64];
    logic [LOG_W-1:0]  m64_log  [N64];
    logic [N64-1:0]    m64_en;
    logic [N64-1:0]    m64_seg;
    logic [GRP_W-1:0]  m64_grp  [N64];

    // state
    dec_state_t        state_q;
    dec_state_t        state_d;
    logic [ADDR_W-1:0] addr_q;

    // compare results
    logic              hit32;
    logic [SEG_W-1:0]  seg32;
    logic [ADDR_W-1:0] xlat32;
    logic [N64-1:0]    hit64;
    logic [SEG_W-1:0]  seg64  [N64];
    logic [ADDR_W-1:0] xlat64 [N64];
    logic              any64;
    logic [IDX_W-1:0]  w64;

    // match stage results
    logic              miss_q;
    logic              is32_q;
    logic [WIN_W-1:0]  win_q;
    logic [GRP_W-1:0]  grp_q;
    logic [ADDR_W-1:0] bus_q;

    mwd_cfg_regs #(
        .ADDR_W(ADDR_W), .N64(N64), .LOG_W(LOG_W),
        .GRP_W(GRP_W), .SEG_W(SEG_W), .CFG_AW(CFG_AW)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .m32_base(m32_base), .m32_upper(m32_upper),
        .m32_log(m32_log), .m32_en(m32_en),
        .m64_base(m64_base), .m64_log(m64_log), .m64_en(m64_en),
        .m64_seg(m64_seg), .m64_grp(m64_grp)
    );

    mwd_seg_table #(.IDX_W(SEG_W), .GRP_W(GRP_W)) tbl_i (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
        .re(state_q == S_MATCH), .raddr(seg32), .rdata(tbl_rdata)
    );

    // 32-bit translating window
    mwd_win_match #(
        .ADDR_W(ADDR_W), .LOG_W(LOG_W), .SEG_W(SEG_W),
        .MIN_LOG(SEG_W), .MAX_LOG(M32_MAX_LOG)
    ) m32_i (
        .addr(addr_q), .base(m32_base), .subst(m32_upper),
        .size_log(m32_log), .en(m32_en),
        .hit(hit32), .seg(seg32), .xlat(xlat32)
    );

    // 64-bit pass-through windows: substitute is the address itself
    for (genvar w = 0; w < N64; w++) begin : g_m64
        mwd_win_match #(
            .ADDR_W(ADDR_W), .LOG_W(LOG_W), .SEG_W(SEG_W),
            .MIN_LOG(M64_MIN_LOG), .MAX_LOG(ADDR_W)
        ) m64_i (
            .addr(addr_q), .base(m64_base[w]), .subst(addr_q),
            .size_log(m64_log[w]), .en(m64_en[w]),
            .hit(hit64[w]), .seg(seg64[w]), .xlat(xlat64[w])
        );
    end

    // lowest-numbered 64-bit hit
    always_comb begin
        any64 = 1'b0;
        w64   = '0;
        for (int i = N64 - 1; i >= 0; i--) begin
            if (hit64[i]) begin
                any64 = 1'b1;
                w64   = IDX_W'(i);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_MATCH;
            S_MATCH:  state_d = S_LOOKUP;
            S_LOOKUP: state_d = S_RESP;
            S_RESP:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    assign req_ready = (state_q == S_IDLE);
    assign rsp_valid = (state_q == S_RESP);

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q       <= '0;
            miss_q       <= 1'b1;
            is32_q       <= 1'b0;
            win_q        <= '0;
            grp_q        <= '0;
            bus_q        <= '0;
            rsp_miss     <= 1'b0;
            rsp_win      <= '0;
            rsp_group    <= '0;
            rsp_bus_addr <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                    end
                end
                S_MATCH: begin
                    miss_q <= !(hit32 || any64);
                    is32_q <= hit32;
                    if (hit32) begin
                        win_q <= M32_ID;
                        grp_q <= '0;
                        bus_q <= xlat32;
                    end else if (any64) begin
                        win_q <= WIN_W'(w64);
                        grp_q <= m64_seg[w64] ? GRP_W'(seg64[w64]) : m64_grp[w64];
                        bus_q <= xlat64[w64];
                    end else begin
                        win_q <= '0;
                        grp_q <= '0;
                        bus_q <= '0;
                    end
                end
                S_LOOKUP: begin
                    rsp_miss     <= miss_q;
                    rsp_win      <= win_q;
                    rsp_group    <= miss_q ? '0 : (is32_q ? tbl_rdata : grp_q);
                    rsp_bus_addr <= bus_q;
                end
                S_RESP: begin
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/mwd_checker.sv
`timescale 1ns/1ps
module mwd_checker
    import mwd_pkg::*;
#(
    parameter int ADDR_W   = mwd_pkg::ADDR_W,
    parameter int N64      = mwd_pkg::N64,
    parameter int GRP_W    = mwd_pkg::GRP_W,
    localparam int WIN_W   = $clog2(N64 + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_miss,
    input logic [WIN_W-1:0]  rsp_win,
    input logic [GRP_W-1:0]  rsp_group,
    input logic [ADDR_W-1:0] rsp_bus_addr
);
    // R2
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    rsp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready, 3));

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_group == '0 && rsp_bus_addr == '0 && rsp_win == '0));

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss && rsp_win != WIN_W'(N64)) |-> rsp_bus_addr == $past(req_addr, 3));

    // R8
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss) |-> rsp_win <= WIN_W'(N64));
endmodule

bind mmio_win_decoder mwd_checker chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr(req_addr),
    .rsp_valid(rsp_valid),
    .rsp_miss(rsp_miss),
    .rsp_win(rsp_win),
    .rsp_group(rsp_group),
    .rsp_bus_addr(rsp_bus_addr)
);

// File: tb/mmio_win_decoder_tb_top.sv
`timescale 1ns/1ps
module mmio_win_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [47:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_miss;
    logic [4:0]  rsp_win;
    logic [7:0]  rsp_group;
    logic [47:0] rsp_bus_addr;

    always #2 clk = ~clk;

    mmio_win_decoder dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
        .rsp_group(rsp_group), .rsp_bus_addr(rsp_bus_addr)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural model of the programmed state
    logic [47:0] mb64 [16];
    int          ml64 [16];
    bit          me64 [16];
    bit          ms64 [16];
    logic [7:0]  mg64 [16];
    logic [47:0] m32b;
    logic [47:0] m32u;
    int          m32l;
    bit          m32e;
    logic [7:0]  mtbl [256];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic void predict(input logic [47:0] a, output logic em, output logic [4:0] ew,
                                    output logic [7:0] eg, output logic [47:0] eb);
        int l;
        logic [47:0] mk;
        em = 1'b1; ew = '0; eg = '0; eb = '0;
        l  = clampi(m32l, 8, 32);
        mk = (48'd1 << l) - 48'd1;
        if (m32e && ((a & ~mk) == (m32b & ~mk))) begin
            em = 1'b0;
            ew = 5'd16;
            eb = (m32u & ~mk) | (a & mk);
            eg = mtbl[int'((a >> (l - 8)) & 48'hFF)];
            return;
        end
        for (int w = 0; w < 16; w++) begin
            l  = clampi(ml64[w], 28, 48);
            mk = (l == 48) ? {48{1'b1}} : ((48'd1 << l) - 48'd1);
            if (me64[w] && ((a & ~mk) == (mb64[w] & ~mk))) begin
                em = 1'b0;
                ew = 5'(w);
                eb = a;
                eg = ms64[w] ? 8'((a >> (l - 8)) & 48'hFF) : mg64[w];
                return;
            end
        end
    endfunction

    task automatic wr(input logic [9:0] ad, input logic [47:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_tbl(input int i, input logic [7:0] g);
        mtbl[i] = g;
        wr(10'(i), {40'b0, g});
    endtask

    task automatic set_m32(input logic [47:0] b, input int l, input bit e, input logic [47:0] u);
        m32b = b; m32l = l; m32e = e; m32u = u;
        wr(10'h100, b);
        wr(10'h101, 48'(l) | (48'(e) << 8));
        wr(10'h102, u);
    endtask

    task automatic set_m64(input int w, input logic [47:0] b, input int l, input bit e,
                           input bit s, input logic [7:0] g);
        mb64[w] = b; ml64[w] = l; me64[w] = e; ms64[w] = s; mg64[w] = g;
        wr(10'h200 + 10'(2 * w), b);
        wr(10'h201 + 10'(2 * w), 48'(l) | (48'(e) << 8) | (48'(s) << 9) | (48'(g) << 16));
    endtask

    task automatic req(input logic [47:0] a, input string tag);
        logic em; logic [4:0] ew; logic [7:0] eg; logic [47:0] eb;
        logic [61:0] av; logic [61:0] ev;
        predict(a, em, ew, eg, eb);
        @(negedge clk);
        chk(req_ready && !rsp_valid, {tag, " R2 idle"}, {62'b0, req_ready, rsp_valid}, 64'h2);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready && !rsp_valid, {tag, " R2 cycle1"}, {62'b0, req_ready, rsp_valid}, 64'h0);
        @(negedge clk);
        chk(!req_ready && !rsp_valid, {tag, " R2 cycle2"}, {62'b0, req_ready, rsp_valid}, 64'h0);
        @(negedge clk);
        chk(!req_ready && rsp_valid, {tag, " R2 cycle3"}, {62'b0, req_ready, rsp_valid}, 64'h1);
        av = {rsp_miss, rsp_win, rsp_group, rsp_bus_addr};
        ev = {em, ew, eg, eb};
        chk(av == ev, {tag, " result"}, 64'(av), 64'(ev));
        @(negedge clk);
        chk(req_ready && !rsp_valid, {tag, " R2 cycle4"}, {62'b0, req_ready, rsp_valid}, 64'h2);
    endtask

    initial begin
        for (int w = 0; w < 16; w++) begin
            mb64[w] = '0; ml64[w] = 0; me64[w] = 0; ms64[w] = 0; mg64[w] = '0;
        end
        for (int i = 0; i < 256; i++) mtbl[i] = '0;
        m32b = '0; m32u = '0; m32l = 0; m32e = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R1 reset handshake", {62'b0, req_ready, rsp_valid}, 64'h2);
        req(48'h0000_8000_0000, "R1 R9 miss after reset");
        req(48'h0010_0000_0000, "R1 R9 miss after reset hi");

        for (int i = 0; i < 256; i++) set_tbl(i, 8'((i * 37 + 11) & 255));

        // 2 GB translating window
        set_m32(48'h0000_8000_0000, 31, 1'b1, 48'h0000_8000_0000);
        req(48'h0000_8000_0000, "R3 R4 R12 seg0");
        req(48'h0000_FFFF_FFFF, "R3 R4 seg255");
        req(48'h0000_9234_5678, "R3 R4 mid");
        req(48'h0000_7FFF_FFFF, "R9 below m32");
        set_m32(48'h0000_8000_0000, 31, 1'b1, 48'h00AB_C000_0000);
        req(48'h0000_C123_4567, "R3 substitute upper");
        // 16 MB window, 64 KB segments
        set_m32(48'h0000_4000_0000, 24, 1'b1, 48'h0000_0000_0000);
        req(48'h0000_40FF_0000, "R4 small seg255");
        req(48'h0000_4001_0000, "R4 small seg1");
        req(48'h0000_4100_0000, "R9 past m32 top");
        set_m32(48'h0000_8000_0000, 31, 1'b1, 48'h0000_8000_0000);

        // 64-bit windows
        set_m64(3, 48'h0010_0000_0000, 32, 1'b1, 1'b1, 8'h00);
        req(48'h0010_1234_5678, "R5 R6 segmented");
        req(48'h0010_FF00_0000, "R6 segmented seg255");
        set_m64(5, 48'h0010_0000_0000, 36, 1'b1, 1'b0, 8'h5A);
        req(48'h0018_0000_0000, "R7 single group");
        req(48'h0010_0000_0010, "R8 overlap lower index");
        req(48'h0020_0000_0000, "R9 past m64 top");
        set_m64(0, 48'h0000_0000_0000, 34, 1'b1, 1'b0, 8'h11);
        req(48'h0000_8000_1000, "R8 m32 beats m64");
        req(48'h0001_0000_0000, "R8 window0");

        // unaligned base
        set_m64(7, 48'h0020_0ABC_1234, 28, 1'b1, 1'b1, 8'h00);
        req(48'h0020_0FFF_FFFF, "R10 aligned hit");
        req(48'h0020_1000_0000, "R10 R9 beyond");

        // size clamp
        set_m64(9, 48'h0030_0000_0000, 4, 1'b1, 1'b1, 8'h00);
        req(48'h0030_0A00_0000, "R6 clamp min");
        req(48'h0030_1000_0000, "R6 clamp edge");

        // disables
        set_m64(0, 48'h0000_0000_0000, 34, 1'b0, 1'b0, 8'h11);
        req(48'h0001_0000_0000, "R11 m64 disabled");
        set_m32(48'h0000_8000_0000, 31, 1'b0, 48'h0000_8000_0000);
        req(48'h0000_8000_1000, "R11 m32 disabled");
        set_m64(3, 48'h0010_0000_0000, 32, 1'b0, 1'b1, 8'h00);
        req(48'h0010_0000_0010, "R11 R8 fall to window5");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog act=0 exp=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule